// File: doc/BRIEF.md
# Fan Failure Supervisor with Spin-Up Retry

This block checks every finished fan-speed measurement against a programmable high limit on the period count. A larger count means a slower fan, so a reading that exceeds the limit is a failure. On each failure the block raises an interrupt and sets a sticky fan-fault bit in a status word. It also forces the fan drive fully on for a fixed spin-up window, which gives a stalled fan a chance to restart.

A streak counter tracks consecutive failures. When the streak reaches five, an active-low fault output asserts, provided it is not masked. Measurements carry on after that point, and further failures still interrupt and still retrigger spin-up. One passing measurement clears the streak and releases the fault.

The PWM waveform from an external duty-cycle generator passes through the block. A polarity bit selects the pin sense for different driver transistors. Reading the status register, signalled by a one-cycle strobe, acknowledges the interrupt.

Top module: `fan_fail_supervisor`

## Requirements
- R1: A measurement strobe counts as a failure exactly when the reading is strictly greater than the limit, so a limit of 0xFE flags only a reading of 0xFF. Readings presented without the strobe have no effect.
- R2: A failure sets `irq` high and sets bit 1 of `stat_word` in the cycle after the strobe edge. All other status bits read 0.
- R3: A one-cycle `status_rd` clears both `irq` and the status bit at the next edge. If a failure arrives on the same edge, the failure wins and both stay set.
- R4: Each failure forces the internal drive fully on for exactly SPIN_TICKS×TICK_DIV clock cycles, starting the cycle after the strobe edge. A failure during the window restarts the full window.
- R5: With `fault_mask` low, `fault_n` goes low only on the fifth consecutive failure and stays high for the first four.
- R6: A passing measurement resets the streak to zero and releases `fault_n` in the next cycle. Failures split by a pass never reach the fault.
- R7: After `fault_n` is low, further failures keep it low and still raise `irq`. The streak saturates at five.
- R8: With `fault_mask` high, `fault_n` stays high. The streak still counts, so clearing the mask exposes a pending fault at once.
- R9: With `pwm_invert` low, `pwm_out` is the complement of the internal drive, so full-on drives the pin low. With `pwm_invert` high, `pwm_out` equals the drive, so full-on drives the pin high. Outside spin-up the drive is `pwm_in`.
- R10: After reset, `irq` is 0, `stat_word` is 0, `fault_n` is 1 and no spin-up window is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| meas_valid | input | 1 | One-cycle strobe: a measurement has completed |
| meas_value | input | DATA_W | Period count of the completed measurement |
| tach_limit | input | DATA_W | High limit on the period count |
| pwm_in | input | 1 | Normal PWM waveform from the duty generator |
| fault_mask | input | 1 | 1 holds the fault output released |
| pwm_invert | input | 1 | Output polarity select |
| status_rd | input | 1 | One-cycle strobe: the status word was read |
| irq | output | 1 | Interrupt, high until acknowledged |
| stat_word | output | 8 | Status word, bit 1 is the sticky fan-fault bit |
| fault_n | output | 1 | Active-low hard fault |
| pwm_out | output | 1 | Final PWM pin drive |

## Verification
The bench sweeps every reading against limits of 0x00, 0x7F, 0xFE and 0xFF. This catches a greater-or-equal compare, which would flag a reading equal to the limit. It also catches a stalled fan being missed at 0xFE. The spin-up window is counted cycle by cycle, including a retrigger part-way through, so an off-by-one tick count or a timer that ignores retriggers shows up as a wrong pin level at the window's edge. The streak is probed at four, five and six failures, across an interrupting pass and under the mask. A design that fired the fault early, cleared on the sixth failure or forgot the streak under the mask would be reported. A read on the same edge as a failure checks that the acknowledge cannot swallow a new event.

// File: rtl/ffs_pkg.sv
// Package: shared constants for the fan failure supervisor.
// Assumes an 8-bit status word with the fan-fault flag at a fixed bit.
package ffs_pkg;
    localparam int STAT_W       = 8;
    localparam int STAT_FAN_BIT = 1;

    // Builds the status word from the sticky fan-fault flag.
    function automatic logic [STAT_W-1:0] pack_status(input logic fan_flag);
        logic [STAT_W-1:0] w;
        w = '0;
        w[STAT_FAN_BIT] = fan_flag;
        return w;
    endfunction
endpackage

// File: rtl/ffs_judge.sv
// Module: ffs_judge
// Compares each measurement against the limit and keeps the
// consecutive-failure streak, saturating at FAIL_LIMIT.
// Assumes meas_valid is a single-cycle strobe.
module ffs_judge #(
    parameter int DATA_W     = 8,
    parameter int FAIL_LIMIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              meas_valid,
    input  logic [DATA_W-1:0] meas_value,
    input  logic [DATA_W-1:0] tach_limit,
    output logic              fail_evt,
    output logic              streak_full
);
    localparam int CW = $clog2(FAIL_LIMIT + 1);
    localparam logic [CW-1:0] LIMIT_C = CW'(FAIL_LIMIT);

    logic [CW-1:0] streak_q;
    logic          over;

    // Strict compare: only a reading above the limit is a failure.
    always_comb over = (meas_value > tach_limit);

    // Qualify the compare with the measurement strobe.
    always_comb fail_evt = meas_valid & over;

    // Count consecutive failures, cleared by any pass, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            streak_q <= '0;
        end else if (meas_valid) begin
            if (!over)
                streak_q <= '0;
            else if (streak_q != LIMIT_C)
                streak_q <= streak_q + 1'b1;
        end
    end

    // Streak has reached the hard-fault threshold.
    always_comb streak_full = (streak_q == LIMIT_C);

    p_pass_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && !over) |=> (streak_q == '0));
    p_fail_counts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && over && streak_q != LIMIT_C) |=> (streak_q == $past(streak_q) + 1'b1));
    p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (streak_q <= LIMIT_C));
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_valid |=> $stable(streak_q));
endmodule

// File: rtl/ffs_spinup.sv
// Module: ffs_spinup
// Retriggerable spin-up window: SPIN_TICKS ticks of TICK_DIV cycles,
// restarted by every failure event.
// Assumes TICK_DIV >= 1 and SPIN_TICKS >= 1.
module ffs_spinup #(
    parameter int TICK_DIV   = 200_000_000,
    parameter int SPIN_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic active
);
    localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int SW = $clog2(SPIN_TICKS + 1);
    localparam logic [TW-1:0] TICK_TOP = TW'(TICK_DIV - 1);
    localparam logic [SW-1:0] SPIN_C   = SW'(SPIN_TICKS);

    logic [TW-1:0] tick_q;
    logic [SW-1:0] rem_q;

    // Load the window on a failure, else count ticks down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
            rem_q  <= '0;
        end else if (load) begin
            tick_q <= TICK_TOP;
            rem_q  <= SPIN_C;
        end else if (rem_q != '0) begin
            if (tick_q == '0) begin
                tick_q <= TICK_TOP;
                rem_q  <= rem_q - 1'b1;
            end else begin
                tick_q <= tick_q - 1'b1;
            end
        end
    end

    // Window is open while ticks remain.
    always_comb active = (rem_q != '0);

    p_load_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (rem_q == SPIN_C && tick_q == TICK_TOP));
    p_idle_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && rem_q == '0) |=> (rem_q == '0));
    p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_q <= SPIN_C));
endmodule

// File: rtl/ffs_irq.sv
// Module: ffs_irq
// Interrupt and sticky status flag: set by failures, cleared by a
// status read; a failure on the same edge as a read takes priority.
module ffs_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic fail_evt,
    input  logic status_rd,
    output logic irq,
    output logic fan_flag
);
    logic irq_q, flag_q;

    // Set on failure, clear on acknowledge, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            flag_q <= 1'b0;
        end else if (fail_evt) begin
            irq_q  <= 1'b1;
            flag_q <= 1'b1;
        end else if (status_rd) begin
            irq_q  <= 1'b0;
            flag_q <= 1'b0;
        end
    end

    // Drive outputs from the registers.
    always_comb begin
        irq      = irq_q;
        fan_flag = flag_q;
    end

    p_fail_raises_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fail_evt |=> (irq_q && flag_q));
    p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !fail_evt) |=> (!irq_q && !flag_q));
    p_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(fail_evt));
endmodule

// File: rtl/ffs_drive.sv
// Module: ffs_drive
// Final PWM stage: spin-up overrides the duty waveform with full-on,
// then the polarity bit selects the pin sense.
module ffs_drive (
    input  logic force_on,
    input  logic pwm_in,
    input  logic pwm_invert,
    output logic pwm_out
);
    logic drive;

    // Select full-on during spin-up, else the normal waveform.
    always_comb drive = force_on ? 1'b1 : pwm_in;

    // Polarity: non-inverted pins are driven low for "on".
    always_comb pwm_out = pwm_invert ? drive : ~drive;

    always_comb begin
        if (force_on)
            p_force_level_r9: assert (pwm_out == pwm_invert);
    end
endmodule

// File: rtl/fan_fail_supervisor.sv
// Module: fan_fail_supervisor
// Top: judges measurements, tracks the failure streak, raises the
// interrupt/status, runs spin-up retries and shapes the PWM pin.
// Assumes strobes are single-cycle and synchronous to clk.
module fan_fail_supervisor #(
    parameter int DATA_W     = 8,
    parameter int FAIL_LIMIT = 5,
    parameter int TICK_DIV   = 200_000_000,
    parameter int SPIN_TICKS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      meas_valid,
    input  logic [DATA_W-1:0]         meas_value,
    input  logic [DATA_W-1:0]         tach_limit,
    input  logic                      pwm_in,
    input  logic                      fault_mask,
    input  logic                      pwm_invert,
    input  logic                      status_rd,
    output logic                      irq,
    output logic [ffs_pkg::STAT_W-1:0] stat_word,
    output logic                      fault_n,
    output logic                      pwm_out
);
    logic fail_evt, streak_full, spin_active, fan_flag;

    ffs_judge #(.DATA_W(DATA_W), .FAIL_LIMIT(FAIL_LIMIT)) u_judge (
        .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid),
        .meas_value(meas_value), .tach_limit(tach_limit),
        .fail_evt(fail_evt), .streak_full(streak_full));

    ffs_spinup #(.TICK_DIV(TICK_DIV), .SPIN_TICKS(SPIN_TICKS)) u_spin (
        .clk(clk), .rst_n(rst_n), .load(fail_evt), .active(spin_active));

    ffs_irq u_irq (
        .clk(clk), .rst_n(rst_n), .fail_evt(fail_evt), .status_rd(status_rd),
        .irq(irq), .fan_flag(fan_flag));

    ffs_drive u_drive (
        .force_on(spin_active), .pwm_in(pwm_in), .pwm_invert(pwm_invert),
        .pwm_out(pwm_out));

    // Assemble the status word.
    always_comb stat_word = ffs_pkg::pack_status(fan_flag);

    // Hard fault follows the saturated streak unless masked.
    always_comb fault_n = ~(streak_full & ~fault_mask);

    p_fault_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fault_n) && !$past(fault_mask) && !fault_mask) |-> $past(fail_evt));
    p_mask_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_mask |-> fault_n);
    p_spin_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fail_evt |=> (spin_active && irq));
endmodule

// File: tb/fan_fail_supervisor_tb.sv
module fan_fail_supervisor_tb;
    localparam int TD = 2;
    localparam int ST = 3;
    localparam int WIN = TD * ST;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic meas_valid = 1'b0;
    logic [7:0] meas_value = '0;
    logic [7:0] tach_limit = '0;
    logic pwm_in = 1'b0;
    logic fault_mask = 1'b0;
    logic pwm_invert = 1'b0;
    logic status_rd = 1'b0;
    logic irq, fault_n, pwm_out;
    logic [7:0] stat_word;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fan_fail_supervisor #(.DATA_W(8), .FAIL_LIMIT(5), .TICK_DIV(TD), .SPIN_TICKS(ST)) u_dut (
        .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_value(meas_value),
        .tach_limit(tach_limit), .pwm_in(pwm_in), .fault_mask(fault_mask),
        .pwm_invert(pwm_invert), .status_rd(status_rd), .irq(irq),
        .stat_word(stat_word), .fault_n(fault_n), .pwm_out(pwm_out));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Present one measurement (optionally with a read), return at next negedge.
    task automatic meas(input logic [7:0] v, input bit rd);
        meas_valid = 1'b1; meas_value = v; status_rd = rd;
        @(posedge clk); @(negedge clk);
        meas_valid = 1'b0; status_rd = 1'b0;
    endtask

    task automatic rd_status();
        status_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        status_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] lims [4];
        lims[0] = 8'h00; lims[1] = 8'h7F; lims[2] = 8'hFE; lims[3] = 8'hFF;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 irq", irq, 0);
        chk("R10 stat", stat_word, 0);
        chk("R10 fault_n", fault_n, 1);
        pwm_in = 1'b1; #0.1;
        chk("R10 no spin", pwm_out, 0);
        pwm_in = 1'b0;

        // R1 sweep: every reading against four limits
        for (int li = 0; li < 4; li++) begin
            tach_limit = lims[li];
            for (int v = 0; v < 256; v++) begin
                meas(v[7:0], 0);
                chk("R1 irq", irq, (v > lims[li]) ? 1 : 0);
                rd_status();
                meas(8'h00, 0);
            end
        end
        // R1 reading without strobe ignored
        tach_limit = 8'h10; meas_value = 8'hFF;
        idle(3);
        chk("R1 no strobe", irq, 0);
        idle(WIN + 2);

        // R2 status bit
        meas(8'hFF, 0);
        chk("R2 irq", irq, 1);
        chk("R2 stat", stat_word, 8'h02);
        idle(2);
        chk("R2 sticky", stat_word, 8'h02);
        // R3 read with simultaneous failure keeps set
        meas(8'hFF, 1);
        chk("R3 collide irq", irq, 1);
        chk("R3 collide stat", stat_word, 8'h02);
        rd_status();
        chk("R3 clear irq", irq, 0);
        chk("R3 clear stat", stat_word, 0);
        meas(8'h00, 0);
        idle(WIN + 2);

        // R4 spin window with pwm_invert=1 (pin = drive), pwm_in=0
        pwm_invert = 1'b1; pwm_in = 1'b0;
        meas(8'hFF, 0);
        chk("R4 open", pwm_out, 1);
        for (int k = 1; k < WIN; k++) begin
            @(negedge clk); chk("R4 within", pwm_out, 1);
        end
        @(negedge clk); chk("R4 closed", pwm_out, 0);
        // R4 retrigger after 3 cycles
        meas(8'h00, 0);
        meas(8'hFF, 0);
        idle(2);
        meas(8'hFF, 0);
        for (int k = 1; k < WIN; k++) begin
            @(negedge clk); chk("R4 retrig", pwm_out, 1);
        end
        @(negedge clk); chk("R4 retrig end", pwm_out, 0);
        meas(8'h00, 0);
        rd_status();

        // R5 streak of five
        for (int n = 1; n <= 5; n++) begin
            meas(8'hFF, 0);
            chk("R5 fault", fault_n, (n == 5) ? 0 : 1);
            rd_status();
        end
        // R7 sixth failure
        meas(8'hFF, 0);
        chk("R7 irq", irq, 1);
        chk("R7 fault held", fault_n, 0);
        rd_status();
        // R6 pass releases
        meas(8'h00, 0);
        chk("R6 release", fault_n, 1);
        // R6 streak split by pass
        for (int n = 0; n < 4; n++) meas(8'hFF, 0);
        meas(8'h00, 0);
        for (int n = 0; n < 4; n++) meas(8'hFF, 0);
        chk("R6 split", fault_n, 1);
        meas(8'h00, 0);

        // R8 mask
        fault_mask = 1'b1;
        for (int n = 0; n < 5; n++) meas(8'hFF, 0);
        chk("R8 masked", fault_n, 1);
        fault_mask = 1'b0; #0.1;
        chk("R8 unmask", fault_n, 0);
        meas(8'h00, 0);
        rd_status();
        idle(WIN + 2);

        // R9 polarity outside spin-up
        for (int inv = 0; inv < 2; inv++) begin
            for (int p = 0; p < 2; p++) begin
                pwm_invert = inv[0]; pwm_in = p[0];
                @(negedge clk);
                chk("R9 polarity", pwm_out, inv ? p : 1 - p);
            end
        end
        // R9 full-on non-inverted drives pin low
        pwm_invert = 1'b0; pwm_in = 1'b0;
        meas(8'hFF, 0);
        chk("R9 spin low", pwm_out, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule